// File: doc/BRIEF.md
# Full-Search Block-Matching Motion Estimator

This block finds the best integer motion vector for one square block of the current frame. Software or an upstream loader first writes the block pixels and a reference window around the block's co-located position into two internal buffers, one pixel per cycle. A start pulse then launches an exhaustive scan: every integer displacement inside a rectangle of ±`RANGE_X` columns by ±`RANGE_Y` rows is scored by the sum of absolute differences (SAD). The horizontal range is normally the larger one, since horizontal motion dominates in typical footage.

The scan visits displacements row by row. The vertical offset is the outer loop and the horizontal offset the inner loop, each ascending from the negative limit to the positive one. Each candidate costs `BLK` cycles, because one block row of differences is accumulated per cycle. When the last candidate is done, a one-cycle done pulse appears. The winning vector and its SAD stay on the outputs until the next accepted start. Motion larger than the ranges cannot be found.

Top module: `fsbm_motion_search`

## Requirements
- R1: Current pixel (row r, column c) is written at `cur_addr = r*BLK + c`. Reference window pixel (row r, column c) is written at `ref_addr = r*(BLK+2*RANGE_X) + c`. A write takes effect when its enable is high at a clock edge.
- R2: The cost of displacement (dx, dy) is the sum over all r, c in [0, BLK) of |cur(r,c) - ref(r+dy+RANGE_Y, c+dx+RANGE_X)|, using unsigned 8-bit pixels.
- R3: After a search, `best_sad` equals the minimum cost over all (2*RANGE_X+1)*(2*RANGE_Y+1) displacements, including the corners of the rectangle, and the vector outputs name a displacement with that cost.
- R4: Among equal minimum costs, the winner is the first in scan order: dy ascending from -RANGE_Y, and within each dy, dx ascending from -RANGE_X. Zero motion gets no preference.
- R5: `mv_dx` and `mv_dy` are two's-complement integers of width clog2(range+1)+1, always within ±RANGE_X and ±RANGE_Y.
- R6: `done` is high for exactly one cycle. It rises exactly (2*RANGE_X+1)*(2*RANGE_Y+1)*BLK clock edges after the edge that accepted `start`.
- R7: `busy` is high from the accepting edge through the done cycle, and low otherwise. A `start` pulse while `busy` is high is ignored: it changes neither the timing nor the result.
- R8: After reset, `busy` and `done` are low and `mv_dx`, `mv_dy` and `best_sad` are zero. Results hold steady while the block is idle.
- R9: `best_sad` is wide enough for the worst case BLK*BLK*255 without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_we | input | 1 | Current-block pixel write enable |
| cur_addr | input | clog2(BLK*BLK) | Current-block pixel address |
| cur_data | input | 8 | Current-block pixel value |
| ref_we | input | 1 | Reference-window pixel write enable |
| ref_addr | input | clog2(window pixels) | Reference-window pixel address |
| ref_data | input | 8 | Reference-window pixel value |
| start | input | 1 | Launch a search when idle |
| busy | output | 1 | Search in progress or completing |
| done | output | 1 | One-cycle completion pulse |
| mv_dx | output | clog2(RANGE_X+1)+1 | Best horizontal displacement, signed |
| mv_dy | output | clog2(RANGE_Y+1)+1 | Best vertical displacement, signed |
| best_sad | output | 8+2*clog2(BLK) | SAD of the best displacement |

## Verification
The assertions assume that `start` is a single-cycle request and that both buffers are written only while `busy` is low. Under those conditions the held results and the timing of the done pulse depend on nothing but the search itself. The stimulus loads all pixels before each launch and never writes during a scan. The bench pulses `start` again mid-scan only to confirm that a request during a scan is ignored. A small configuration (4x4 block, ±2 by ±1) is swept over every planted match position, all-equal and saturating pixel fields. Expected vectors and costs come from an arithmetic full-search model inside the bench.

// File: rtl/fsbm_pkg.sv
package fsbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } fsbm_state_e;

    localparam int PIX_W = 8;
endpackage

// File: rtl/fsbm_pixel_store.sv
module fsbm_pixel_store #(
    parameter int PW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [PW-1:0]         wdata,
    output logic [DEPTH*PW-1:0]   flat
);
    logic [PW-1:0] mem_d [DEPTH];
    logic [PW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (int'(addr) < DEPTH)) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat[g*PW +: PW] = mem_q[g];
    end
endmodule

// File: rtl/fsbm_row_sad.sv
module fsbm_row_sad #(
    parameter int PW  = 8,
    parameter int BLK = 16,
    parameter int SW  = 16
) (
    input  logic [BLK*PW-1:0] cur_row,
    input  logic [BLK*PW-1:0] ref_row,
    output logic [SW-1:0]     row_sad
);
    logic [PW-1:0] diff [BLK];

    for (genvar g = 0; g < BLK; g++) begin : g_absdiff
        logic [PW-1:0] a_pix;
        logic [PW-1:0] b_pix;
        assign a_pix   = cur_row[g*PW +: PW];
        assign b_pix   = ref_row[g*PW +: PW];
        assign diff[g] = (a_pix >= b_pix) ? (a_pix - b_pix) : (b_pix - a_pix);
    end

    always_comb begin
        row_sad = '0;
        for (int i = 0; i < BLK; i++) begin
            row_sad = row_sad + SW'(diff[i]);
        end
    end
endmodule

// File: rtl/fsbm_scan_ctrl.sv
module fsbm_scan_ctrl
    import fsbm_pkg::*;
#(
    parameter int BLK     = 16,
    parameter int RANGE_X = 8,
    parameter int RANGE_Y = 4,
    parameter int SW      = 16,
    localparam int RIW    = (BLK > 1) ? $clog2(BLK) : 1,
    localparam int NX     = 2 * RANGE_X + 1,
    localparam int NY     = 2 * RANGE_Y + 1,
    localparam int CXW    = (NX > 1) ? $clog2(NX) : 1,
    localparam int CYW    = (NY > 1) ? $clog2(NY) : 1,
    localparam int DXW    = $clog2(RANGE_X + 1) + 1,
    localparam int DYW    = $clog2(RANGE_Y + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SW-1:0]    row_sad,
    output logic [RIW-1:0]   row_idx,
    output logic [CXW-1:0]   cx_idx,
    output logic [CYW-1:0]   cy_idx,
    output logic             busy,
    output logic             done,
    output logic [DXW-1:0]   mv_dx,
    output logic [DYW-1:0]   mv_dy,
    output logic [SW-1:0]    best_sad
);
    typedef struct packed {
        fsbm_state_e     st;
        logic [RIW-1:0]  row;
        logic [CXW-1:0]  cx;
        logic [CYW-1:0]  cy;
        logic [SW-1:0]   acc;
        logic            have;
        logic [SW-1:0]   best;
        logic [CXW-1:0]  bx;
        logic [CYW-1:0]  by;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [SW-1:0] cand_sum;

    always_comb begin
        ctl_d    = ctl_q;
        cand_sum = ctl_q.acc + row_sad;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_RUN;
                    ctl_d.row  = '0;
                    ctl_d.cx   = '0;
                    ctl_d.cy   = '0;
                    ctl_d.acc  = '0;
                    ctl_d.have = 1'b0;
                end
            end
            ST_RUN: begin
                if (ctl_q.row == RIW'(BLK - 1)) begin
                    ctl_d.row = '0;
                    ctl_d.acc = '0;
                    if (!ctl_q.have || (cand_sum < ctl_q.best)) begin
                        ctl_d.best = cand_sum;
                        ctl_d.bx   = ctl_q.cx;
                        ctl_d.by   = ctl_q.cy;
                        ctl_d.have = 1'b1;
                    end
                    if (ctl_q.cx == CXW'(NX - 1)) begin
                        ctl_d.cx = '0;
                        if (ctl_q.cy == CYW'(NY - 1)) begin
                            ctl_d.st = ST_DONE;
                        end else begin
                            ctl_d.cy = ctl_q.cy + 1'b1;
                        end
                    end else begin
                        ctl_d.cx = ctl_q.cx + 1'b1;
                    end
                end else begin
                    ctl_d.row = ctl_q.row + 1'b1;
                    ctl_d.acc = cand_sum;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.bx   <= CXW'(RANGE_X);
            ctl_q.by   <= CYW'(RANGE_Y);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign row_idx  = ctl_q.row;
    assign cx_idx   = ctl_q.cx;
    assign cy_idx   = ctl_q.cy;
    assign busy     = (ctl_q.st != ST_IDLE);
    assign done     = (ctl_q.st == ST_DONE);
    assign mv_dx    = DXW'(ctl_q.bx) - DXW'(RANGE_X);
    assign mv_dy    = DYW'(ctl_q.by) - DYW'(RANGE_Y);
    assign best_sad = ctl_q.best;
endmodule

// File: rtl/fsbm_motion_search.sv
module fsbm_motion_search
    import fsbm_pkg::*;
#(
    parameter int BLK     = 16,
    parameter int RANGE_X = 8,
    parameter int RANGE_Y = 4,
    localparam int WIN_W  = BLK + 2 * RANGE_X,
    localparam int WIN_H  = BLK + 2 * RANGE_Y,
    localparam int CDEPTH = BLK * BLK,
    localparam int RDEPTH = WIN_W * WIN_H,
    localparam int CAW    = $clog2(CDEPTH),
    localparam int RAW    = $clog2(RDEPTH),
    localparam int SW     = PIX_W + 2 * $clog2(BLK),
    localparam int DXW    = $clog2(RANGE_X + 1) + 1,
    localparam int DYW    = $clog2(RANGE_Y + 1) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cur_we,
    input  logic [CAW-1:0]     cur_addr,
    input  logic [PIX_W-1:0]   cur_data,
    input  logic               ref_we,
    input  logic [RAW-1:0]     ref_addr,
    input  logic [PIX_W-1:0]   ref_data,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic [DXW-1:0]     mv_dx,
    output logic [DYW-1:0]     mv_dy,
    output logic [SW-1:0]      best_sad
);
    localparam int RIW = (BLK > 1) ? $clog2(BLK) : 1;
    localparam int NX  = 2 * RANGE_X + 1;
    localparam int NY  = 2 * RANGE_Y + 1;
    localparam int CXW = (NX > 1) ? $clog2(NX) : 1;
    localparam int CYW = (NY > 1) ? $clog2(NY) : 1;
    localparam int CBW = $clog2(CDEPTH * PIX_W);
    localparam int RBW = $clog2(RDEPTH * PIX_W);

    logic [CDEPTH*PIX_W-1:0] cur_flat;
    logic [RDEPTH*PIX_W-1:0] ref_flat;
    logic [RIW-1:0]          row_idx;
    logic [CXW-1:0]          cx_idx;
    logic [CYW-1:0]          cy_idx;
    logic [CBW-1:0]          cur_base;
    logic [RBW-1:0]          ref_base;
    logic [BLK*PIX_W-1:0]    cur_row;
    logic [BLK*PIX_W-1:0]    ref_row;
    logic [SW-1:0]           row_sad;

    fsbm_pixel_store #(.PW(PIX_W), .DEPTH(CDEPTH)) u_cur_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cur_we),
        .addr  (cur_addr),
        .wdata (cur_data),
        .flat  (cur_flat)
    );

    fsbm_pixel_store #(.PW(PIX_W), .DEPTH(RDEPTH)) u_ref_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ref_we),
        .addr  (ref_addr),
        .wdata (ref_data),
        .flat  (ref_flat)
    );

    always_comb begin
        cur_base = CBW'(row_idx) * CBW'(BLK * PIX_W);
        ref_base = ((RBW'(row_idx) + RBW'(cy_idx)) * RBW'(WIN_W) + RBW'(cx_idx))
                   * RBW'(PIX_W);
        cur_row  = cur_flat[cur_base +: BLK*PIX_W];
        ref_row  = ref_flat[ref_base +: BLK*PIX_W];
    end

    fsbm_row_sad #(.PW(PIX_W), .BLK(BLK), .SW(SW)) u_row_sad (
        .cur_row (cur_row),
        .ref_row (ref_row),
        .row_sad (row_sad)
    );

    fsbm_scan_ctrl #(.BLK(BLK), .RANGE_X(RANGE_X), .RANGE_Y(RANGE_Y), .SW(SW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .row_sad  (row_sad),
        .row_idx  (row_idx),
        .cx_idx   (cx_idx),
        .cy_idx   (cy_idx),
        .busy     (busy),
        .done     (done),
        .mv_dx    (mv_dx),
        .mv_dy    (mv_dy),
        .best_sad (best_sad)
    );
endmodule

// File: rtl/fsbm_motion_search_chk.sv
module fsbm_motion_search_chk #(
    parameter int BLK     = 16,
    parameter int RANGE_X = 8,
    parameter int RANGE_Y = 4,
    parameter int SW      = 16,
    parameter int DXW     = 5,
    parameter int DYW     = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [DXW-1:0] mv_dx,
    input logic [DYW-1:0] mv_dy,
    input logic [SW-1:0]  best_sad
);
    localparam int SCAN_CYC = (2 * RANGE_X + 1) * (2 * RANGE_Y + 1) * BLK;
    localparam int SAD_MAX  = BLK * BLK * 255;

    int lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= 0;
        end else if (start && !busy) begin
            lat_q <= 0;
        end else if (busy) begin
            lat_q <= lat_q + 1;
        end
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == SCAN_CYC));

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(mv_dx) && $stable(mv_dy) && $stable(best_sad)));

    p_mv_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(mv_dx) >= -RANGE_X) && ($signed(mv_dx) <= RANGE_X) &&
        ($signed(mv_dy) >= -RANGE_Y) && ($signed(mv_dy) <= RANGE_Y));

    p_sad_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(best_sad) <= SAD_MAX);
endmodule

bind fsbm_motion_search fsbm_motion_search_chk #(
    .BLK(BLK), .RANGE_X(RANGE_X), .RANGE_Y(RANGE_Y), .SW(SW), .DXW(DXW), .DYW(DYW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mv_dx    (mv_dx),
    .mv_dy    (mv_dy),
    .best_sad (best_sad)
);

// File: tb/fsbm_motion_search_tb.sv
`timescale 1ns/1ps
module fsbm_motion_search_tb_top;
    localparam int BLK   = 4;
    localparam int RX    = 2;
    localparam int RY    = 1;
    localparam int WW    = BLK + 2 * RX;
    localparam int WH    = BLK + 2 * RY;
    localparam int CD    = BLK * BLK;
    localparam int RD    = WW * WH;
    localparam int CAW   = $clog2(CD);
    localparam int RAW   = $clog2(RD);
    localparam int SW    = 8 + 2 * $clog2(BLK);
    localparam int DXW   = $clog2(RX + 1) + 1;
    localparam int DYW   = $clog2(RY + 1) + 1;
    localparam int NCAND = (2 * RX + 1) * (2 * RY + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cur_we = 1'b0;
    logic [CAW-1:0] cur_addr = '0;
    logic [7:0]     cur_data = '0;
    logic           ref_we = 1'b0;
    logic [RAW-1:0] ref_addr = '0;
    logic [7:0]     ref_data = '0;
    logic           start = 1'b0;
    logic           busy;
    logic           done;
    logic [DXW-1:0] mv_dx;
    logic [DYW-1:0] mv_dy;
    logic [SW-1:0]  best_sad;

    int n_checks = 0;
    int n_errors = 0;
    int cur_px [CD];
    int ref_px [RD];

    always #2 clk = ~clk;

    fsbm_motion_search #(.BLK(BLK), .RANGE_X(RX), .RANGE_Y(RY)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cur_we(cur_we), .cur_addr(cur_addr), .cur_data(cur_data),
        .ref_we(ref_we), .ref_addr(ref_addr), .ref_data(ref_data),
        .start(start), .busy(busy), .done(done),
        .mv_dx(mv_dx), .mv_dy(mv_dy), .best_sad(best_sad)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pix(input int i, input int seed);
        return ((i * 73 + seed * 29 + 7) ^ (i * i * 5 + seed)) & 255;
    endfunction

    // R1 addressing: cur r*BLK+c, ref r*WW+c
    task automatic load_buffers();
        for (int i = 0; i < CD; i++) begin
            @(negedge clk);
            cur_we = 1'b1; cur_addr = CAW'(i); cur_data = 8'(cur_px[i]);
        end
        @(negedge clk);
        cur_we = 1'b0;
        for (int i = 0; i < RD; i++) begin
            @(negedge clk);
            ref_we = 1'b1; ref_addr = RAW'(i); ref_data = 8'(ref_px[i]);
        end
        @(negedge clk);
        ref_we = 1'b0;
    endtask

    // Independent full-search model (R2, R3, R4)
    task automatic model(output int edx, output int edy, output int esad);
        esad = -1; edx = 0; edy = 0;
        for (int dy = -RY; dy <= RY; dy++) begin
            for (int dx = -RX; dx <= RX; dx++) begin
                int s = 0;
                for (int r = 0; r < BLK; r++) begin
                    for (int c = 0; c < BLK; c++) begin
                        int d = cur_px[r*BLK + c] - ref_px[(r + dy + RY)*WW + c + dx + RX];
                        s += (d < 0) ? -d : d;
                    end
                end
                if (esad < 0 || s < esad) begin
                    esad = s; edx = dx; edy = dy;
                end
            end
        end
    endtask

    task automatic run_and_check(input string tag, input bit poke);
        int lat;
        int edx, edy, esad;
        model(edx, edy, esad);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        while (!done) begin
            @(negedge clk);
            lat++;
            start = (poke && lat == 3) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        check({tag, " R6 latency"}, lat, NCAND * BLK);
        check({tag, " R3 sad"}, int'(best_sad), esad);
        check({tag, " R4/R5 mv_dx"}, int'($signed(mv_dx)), edx);
        check({tag, " R4/R5 mv_dy"}, int'($signed(mv_dy)), edy);
        @(negedge clk);
        check({tag, " R6 done one cycle"}, int'(done), 0);
        check({tag, " R7 busy dropped"}, int'(busy), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 reset busy", int'(busy), 0);
        check("R8 reset done", int'(done), 0);
        check("R8 reset mv_dx", int'(mv_dx), 0);
        check("R8 reset mv_dy", int'(mv_dy), 0);
        check("R8 reset sad", int'(best_sad), 0);

        // R3/R1: planted exact match at every displacement, corners included
        for (int oy = -RY; oy <= RY; oy++) begin
            for (int ox = -RX; ox <= RX; ox++) begin
                for (int i = 0; i < RD; i++) ref_px[i] = pix(i, 3 + ox + 5 * oy + 20);
                for (int i = 0; i < CD; i++) cur_px[i] = pix(i, 91);
                for (int r = 0; r < BLK; r++)
                    for (int c = 0; c < BLK; c++)
                        ref_px[(r + oy + RY)*WW + c + ox + RX] = cur_px[r*BLK + c];
                load_buffers();
                run_and_check("planted", 1'b0);
                check("R3 planted dx", int'($signed(mv_dx)), ox);
                check("R3 planted dy", int'($signed(mv_dy)), oy);
            end
        end

        // R2: no exact match, generic pseudo-random field
        for (int i = 0; i < RD; i++) ref_px[i] = pix(i, 5);
        for (int i = 0; i < CD; i++) cur_px[i] = pix(i, 77);
        load_buffers();
        run_and_check("random", 1'b0);

        // R4: all-equal field, every candidate ties, first in scan order wins
        for (int i = 0; i < RD; i++) ref_px[i] = 40;
        for (int i = 0; i < CD; i++) cur_px[i] = 40;
        load_buffers();
        run_and_check("tie", 1'b0);
        check("R4 tie dx", int'($signed(mv_dx)), -RX);
        check("R4 tie dy", int'($signed(mv_dy)), -RY);

        // R9: saturating difference
        for (int i = 0; i < RD; i++) ref_px[i] = 0;
        for (int i = 0; i < CD; i++) cur_px[i] = 255;
        load_buffers();
        run_and_check("max", 1'b0);
        check("R9 max sad", int'(best_sad), BLK * BLK * 255);

        // R7: start pulse during scan is ignored
        for (int i = 0; i < RD; i++) ref_px[i] = pix(i, 13);
        for (int i = 0; i < CD; i++) cur_px[i] = pix(i, 200);
        load_buffers();
        run_and_check("restart", 1'b1);

        // R8: results hold while idle
        begin
            int hx, hy, hs;
            hx = int'(mv_dx); hy = int'(mv_dy); hs = int'(best_sad);
            repeat (6) @(negedge clk);
            check("R8 hold mv_dx", int'(mv_dx), hx);
            check("R8 hold mv_dy", int'(mv_dy), hy);
            check("R8 hold sad", int'(best_sad), hs);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule